// File: doc/BRIEF.md
# Three-Wire Divider Configuration Port

This block receives divider settings for a frequency synthesizer over a three-wire serial port made of a serial clock, a serial data line and a load-enable line. It sits in the system clock domain. All three serial lines are brought in through a synchronizer, and the edges of the serial clock and load enable are detected there. Bits are collected into one 19-bit shift word, most significant bit first. When load enable rises, the word is copied into one of two holding latches.

The bit shifted in last is the steering bit. When it is low, the word goes to the divider latch, which holds the swallow count and the main count. When it is high, the word goes to the reference latch, which holds the 14-bit reference divide value and four mode flags: prescaler modulus, detector polarity, lock-output select and charge-pump current. The other latch keeps its contents. Divide values below the smallest legal ratio are raised to that minimum as they are stored. The latched fields are the block's outputs.

Top module: `ser_load_if`

## Requirements
- R1: While `rst` is high, and afterwards until the first transfer, the outputs hold these defaults: swallow 0, main 3, reference 3, and all four mode flags 0.
- R2: A bit is taken from the data line at each rising edge of the serial clock that occurs while load enable is low. Bits arrive most significant first. Only the last 19 bits shifted in form the word, so position 19 is the first of those bits and position 1 is the last.
- R3: A rising edge of load enable with position 1 equal to 0 loads the divider latch. Positions 2 to 8 give the swallow count, with its LSB at position 2. Positions 9 to 19 give the main count, with its LSB at position 9.
- R4: A rising edge of load enable with position 1 equal to 1 loads the reference latch. Positions 2 to 15 give the reference value, with its LSB at position 2. The flags are: position 16 prescaler modulus, position 17 detector polarity, position 18 lock-output select, position 19 charge-pump current.
- R5: A transfer leaves every field of the latch that was not selected unchanged.
- R6: Rising edges of the serial clock while load enable is high do not change the shift word. A later load-enable rise therefore transfers the word shifted in before load enable went high.
- R7: A reference value or a main count below 3 is stored as 3.
- R8: Exactly one transfer happens per rising edge of load enable. Outputs change only on a transfer, and they settle within SYNC_STAGES+1 system clocks after load enable is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_le_i | input | 1 | Load enable, asynchronous |
| swallow_o | output | 7 | Latched swallow count |
| main_o | output | 11 | Latched main count |
| ref_div_o | output | 14 | Latched reference divide value |
| mod_sel_o | output | 1 | Prescaler modulus select flag |
| pfd_pol_o | output | 1 | Detector polarity flag |
| lock_sel_o | output | 1 | Lock-output select flag |
| cp_hi_o | output | 1 | Charge-pump current select flag |

## Verification
The bench aims at corner cases where a wrong design gives visibly wrong fields:
- All-ones and all-zeros fields. A design that swapped or shifted a field boundary would show wrong values here.
- Words the steering bit sends to each latch. A design that decoded both latches on every load would corrupt the other latch's fields.
- Reference values of 1 and 2 and a main count of 0. A design that stored them without raising them to the minimum would output them unchanged.
- Extra leading bits before a word. A design that kept those stale bits would mis-place the fields.
- Clock pulses sent while load enable is high. A design that shifted them in would transfer the wrong word on the next load.

// File: rtl/ser_load_pkg.sv
package ser_load_pkg;

  // Field order matches the top four word positions (19 down to 16),
  // so a slice of the word casts straight into this type.
  typedef struct packed {
    logic cp_hi;
    logic lock_sel;
    logic pfd_pol;
    logic mod_sel;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  typedef enum logic {
    SEL_DIVIDER   = 1'b0,
    SEL_REFERENCE = 1'b1
  } latch_sel_e;

endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ser_edge.sv
module ser_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  for (genvar b = 0; b < W; b++) begin : g_rise
    assign rise_o[b] = lvl_i[b] & ~prev_q[b];
  end

endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int WORD_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-1:0] word_q;

  // New bits enter at the bottom, so the oldest kept bit ends at the top.
  always_ff @(posedge clk) begin
    if (rst)           word_q <= '0;
    else if (shift_en) word_q <= {word_q[WORD_W-2:0], bit_i};
  end

  assign word_o = word_q;

endmodule

// File: rtl/ser_latch_bank.sv
module ser_latch_bank
  import ser_load_pkg::*;
#(
  parameter int A_W     = 7,
  parameter int B_W     = 11,
  parameter int R_W     = 14,
  parameter int MIN_DIV = 3,
  parameter int WORD_W  = 1 + A_W + B_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [A_W-1:0]    swallow_o,
  output logic [B_W-1:0]    main_o,
  output logic [R_W-1:0]    ref_o,
  output mode_t             mode_o
);

  localparam logic [B_W-1:0] B_MIN = B_W'(MIN_DIV);
  localparam logic [R_W-1:0] R_MIN = R_W'(MIN_DIV);
  localparam int A_LO = 1;
  localparam int B_LO = A_LO + A_W;
  localparam int R_LO = 1;
  localparam int M_LO = R_LO + R_W;

  latch_sel_e        sel;
  logic [A_W-1:0]    a_field;
  logic [B_W-1:0]    b_raw, b_field;
  logic [R_W-1:0]    r_raw, r_field;
  mode_t             m_field;

  assign sel     = latch_sel_e'(word_i[0]);
  assign a_field = word_i[B_LO-1:A_LO];
  assign b_raw   = word_i[B_LO+B_W-1:B_LO];
  assign r_raw   = word_i[M_LO-1:R_LO];
  assign m_field = mode_t'(word_i[M_LO+MODE_W-1:M_LO]);

  if (MIN_DIV > 0) begin : g_clamp
    assign b_field = (b_raw < B_MIN) ? B_MIN : b_raw;
    assign r_field = (r_raw < R_MIN) ? R_MIN : r_raw;
  end else begin : g_pass
    assign b_field = b_raw;
    assign r_field = r_raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      swallow_o <= '0;
      main_o    <= B_MIN;
    end else if (load_i && sel == SEL_DIVIDER) begin
      swallow_o <= a_field;
      main_o    <= b_field;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_o  <= R_MIN;
      mode_o <= '0;
    end else if (load_i && sel == SEL_REFERENCE) begin
      ref_o  <= r_field;
      mode_o <= m_field;
    end
  end

endmodule

// File: rtl/ser_load_if.sv
module ser_load_if
  import ser_load_pkg::*;
#(
  parameter int A_W         = 7,
  parameter int B_W         = 11,
  parameter int R_W         = 14,
  parameter int MIN_DIV     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ser_clk_i,
  input  logic           ser_dat_i,
  input  logic           ser_le_i,
  output logic [A_W-1:0] swallow_o,
  output logic [B_W-1:0] main_o,
  output logic [R_W-1:0] ref_div_o,
  output logic           mod_sel_o,
  output logic           pfd_pol_o,
  output logic           lock_sel_o,
  output logic           cp_hi_o
);

  localparam int WORD_W = 1 + A_W + B_W;

  logic [2:0]        sync_lvl;
  logic [1:0]        rise;
  logic              dat_s, sclk_s, le_s;
  logic              shift_en, load_stb;
  logic [WORD_W-1:0] word;
  mode_t             mode;

  ser_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ser_le_i, ser_clk_i, ser_dat_i}),
    .sync_o  (sync_lvl)
  );

  assign {le_s, sclk_s, dat_s} = sync_lvl;

  ser_edge #(.W(2)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  ({le_s, sclk_s}),
    .rise_o (rise)
  );

  assign shift_en = rise[0] & ~le_s;
  assign load_stb = rise[1];

  ser_shift #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .bit_i    (dat_s),
    .word_o   (word)
  );

  ser_latch_bank #(
    .A_W(A_W), .B_W(B_W), .R_W(R_W), .MIN_DIV(MIN_DIV), .WORD_W(WORD_W)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load_stb),
    .word_i    (word),
    .swallow_o (swallow_o),
    .main_o    (main_o),
    .ref_o     (ref_div_o),
    .mode_o    (mode)
  );

  assign mod_sel_o  = mode.mod_sel;
  assign pfd_pol_o  = mode.pfd_pol;
  assign lock_sel_o = mode.lock_sel;
  assign cp_hi_o    = mode.cp_hi;

endmodule

// File: rtl/ser_load_if_chk.sv
module ser_load_if_chk #(
  parameter int A_W     = 7,
  parameter int B_W     = 11,
  parameter int R_W     = 14,
  parameter int MIN_DIV = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           load_stb,
  input logic           sel_bit,
  input logic [A_W-1:0] swallow_o,
  input logic [B_W-1:0] main_o,
  input logic [R_W-1:0] ref_div_o,
  input logic [3:0]     mode_bits
);

  // R1: defaults right after reset is released
  a_r1_reset_defaults: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (swallow_o == '0 && main_o == B_W'(MIN_DIV) &&
                    ref_div_o == R_W'(MIN_DIV) && mode_bits == '0));

  // R5: a divider load leaves the reference latch alone
  a_r5_div_keeps_ref: assert property (@(posedge clk) disable iff (rst)
    (load_stb && !sel_bit) |=> ($stable(ref_div_o) && $stable(mode_bits)));

  // R5: a reference load leaves the divider latch alone
  a_r5_ref_keeps_div: assert property (@(posedge clk) disable iff (rst)
    (load_stb && sel_bit) |=> ($stable(swallow_o) && $stable(main_o)));

  // R7: stored divide values never fall below the minimum
  a_r7_ref_min: assert property (@(posedge clk) disable iff (rst)
    ref_div_o >= R_W'(MIN_DIV));

  a_r7_main_min: assert property (@(posedge clk) disable iff (rst)
    main_o >= B_W'(MIN_DIV));

  // R8: outputs move only on a transfer
  a_r8_stable_no_load: assert property (@(posedge clk) disable iff (rst)
    !load_stb |=> ($stable(swallow_o) && $stable(main_o) &&
                   $stable(ref_div_o) && $stable(mode_bits)));

  // R8: one strobe per load-enable rise
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> !load_stb);

endmodule

bind ser_load_if ser_load_if_chk #(
  .A_W(A_W), .B_W(B_W), .R_W(R_W), .MIN_DIV(MIN_DIV)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load_stb  (load_stb),
  .sel_bit   (word[0]),
  .swallow_o (swallow_o),
  .main_o    (main_o),
  .ref_div_o (ref_div_o),
  .mode_bits ({cp_hi_o, lock_sel_o, pfd_pol_o, mod_sel_o})
);

// File: tb/ser_load_if_tb.sv
module ser_load_if_tb;

  localparam int HALF = 3;
  localparam int NVEC = 8;

  // Word positions: bit k-1 of each vector is position k.
  localparam logic [18:0] VECS [NVEC] = '{
    {11'd100,  7'd5,   1'b0},
    {1'b0, 1'b1, 1'b0, 1'b1, 14'd1000, 1'b1},
    {11'd2047, 7'd127, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b1, 14'd16383, 1'b1},
    {11'd0,    7'd0,   1'b0},
    {1'b0, 1'b0, 1'b0, 1'b0, 14'd1, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b0, 14'd2, 1'b1},
    {11'd3,    7'd64,  1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
  logic [6:0]  swallow;
  logic [10:0] main_cnt;
  logic [13:0] ref_div;
  logic mod_sel, pfd_pol, lock_sel, cp_hi;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  logic [6:0]  exp_a;
  logic [10:0] exp_b;
  logic [13:0] exp_r;
  logic [3:0]  exp_m;

  always #10 clk = ~clk;

  ser_load_if u_dut (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_le_i(sle),
    .swallow_o(swallow), .main_o(main_cnt), .ref_div_o(ref_div),
    .mod_sel_o(mod_sel), .pfd_pol_o(pfd_pol), .lock_sel_o(lock_sel), .cp_hi_o(cp_hi)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = v[i];
      tick(HALF);
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic strobe();
    tick(HALF);
    sle = 1'b1;
    tick(8);
    sle = 1'b0;
    tick(HALF);
  endtask

  // Expected-state model built from R3, R4, R5 and R7.
  task automatic model(input logic [18:0] w);
    if (w[0]) begin
      exp_r = (w[14:1] < 14'd3) ? 14'd3 : w[14:1];
      exp_m = w[18:15];
    end else begin
      exp_a = w[7:1];
      exp_b = (w[18:8] < 11'd3) ? 11'd3 : w[18:8];
    end
  endtask

  task automatic check_all(input string dtag, input string rtag);
    chk({dtag, " swallow"}, 32'(swallow), 32'(exp_a));
    chk({dtag, " main"}, 32'(main_cnt), 32'(exp_b));
    chk({rtag, " reference"}, 32'(ref_div), 32'(exp_r));
    chk({rtag, " flags"}, 32'({cp_hi, lock_sel, pfd_pol, mod_sel}), 32'(exp_m));
  endtask

  task automatic reset_model();
    exp_a = '0; exp_b = 11'd3; exp_r = 14'd3; exp_m = '0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    reset_model();
    tick(5);
    rst = 1'b0;
    tick(3);
    check_all("R1 reset", "R1 reset");

    // Vector table: one word per entry, both latches checked after each.
    for (int v = 0; v < NVEC; v++) begin
      shift_bits(32'(VECS[v]), 19);
      strobe();
      model(VECS[v]);
      check_all("R2 R3 R5 R7 divider", "R2 R4 R5 R7 reference");
    end

    // R2: extra leading bits are pushed out; only the last 19 count.
    shift_bits({9'd0, 4'b1011, 1'b1, 1'b0, 1'b1, 1'b0, 14'd12345, 1'b1}, 23);
    strobe();
    model({1'b1, 1'b0, 1'b1, 1'b0, 14'd12345, 1'b1});
    check_all("R2 long word divider", "R2 long word reference");

    // R6: clocks while load enable is high do not shift.
    shift_bits(32'({11'd500, 7'd9, 1'b0}), 19);
    tick(HALF);
    sle = 1'b1;
    tick(8);
    model({11'd500, 7'd9, 1'b0});
    shift_bits(32'({1'b1, 1'b1, 1'b1, 1'b1, 14'd777, 1'b1}), 19);
    tick(2);
    sle = 1'b0;
    tick(HALF);
    strobe();
    check_all("R6 R8 held word divider", "R6 R8 held word reference");

    // R1: reset in mid-run restores defaults.
    @(negedge clk);
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(2);
    reset_model();
    check_all("R1 rerun divider", "R1 rerun reference");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule